// File: doc/BRIEF.md
# Variable-Length SPI Master Exchange Engine

This block is a single-lane SPI master that sends one word and captures the slave's reply in the same pass. The word can be 1 to 16 bits long. The host loads a transmit word, chooses the word length and the clock phase, and then pulses a start input. The engine drives the serial clock, the data-out line and an active-low select. It clocks in the slave's bits and stores each finished reply in an eight-entry receive queue. The host reads the oldest reply through the data output and removes it from the queue with a read strobe.

A three-state machine runs the serial side. `XE_IDLE` holds the clock low and the select high. `XE_LOW` is the low half of a bit period and `XE_HIGH` is the high half. Each half lasts `DIV/2` system clocks. The named transitions are:

- **launch** (`XE_IDLE`→`XE_LOW`): start while enabled.
- **rise** (`XE_LOW`→`XE_HIGH`): end of the low half.
- **fall** (`XE_HIGH`→`XE_LOW`): end of a high half that is not the final bit.
- **finish** (`XE_HIGH`→`XE_IDLE`): end of the final bit's high half.
- **abort** (`XE_LOW` or `XE_HIGH` → `XE_IDLE`): the enable input drops.

Top module: `spi_xchg_master`

## Requirements
- R1: When idle, `sclk_o` is 0 and `cs_n_o` is 1. An N-bit exchange holds `cs_n_o` low for N bit periods. Each bit period is DIV/2 clocks with `sclk_o` low, then DIV/2 clocks with `sclk_o` high. `sclk_o` is never high while `cs_n_o` is high.
- R2: With `phase_i`=0, `mosi_o` shows bit N-1 of the loaded word from the cycle after the write, before any clock edge. Each following bit appears after a falling edge of `sclk_o`.
- R3: With `phase_i`=1, `mosi_o` is 0 while idle and during the first low half. Each bit appears after a rising edge of `sclk_o`, with bit N-1 first.
- R4: A start pulse is accepted only while `enable_i`=1 and the block is idle. `busy_o` then reads 1 from the next cycle. It returns to 0 in the cycle after the last falling edge, together with `sclk_o` low and `cs_n_o` high.
- R5: The length is coded as `len_i` = N-1. Bits are sent most-significant first, starting at bit N-1 of the loaded word. Bits N..15 are never sent.
- R6: `miso_i` is sampled on the rising edge when `phase_i`=0 and on the falling edge when `phase_i`=1. The stored reply is right-justified: the last sampled bit is at bit 0 and bits N..15 are 0.
- R7: A data write (`wr_i`) has no effect while `enable_i`=0 or while `busy_o`=1.
- R8: `rdata_o` shows the oldest queued reply, or 0x0000 when the queue is empty, including after reset. A read strobe removes that entry.
- R9: `rx_ready_o` is 1 exactly while the queue holds at least one reply. It clears after the read that empties the queue.
- R10: The queue holds 8 replies. A reply that completes while all 8 entries are full is discarded.
- R11: If `enable_i` drops during an exchange, the next cycle is idle (R1 levels) and no reply is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Block enable; dropping it aborts an exchange |
| start_i | input | 1 | Start pulse for an exchange |
| phase_i | input | 1 | Clock phase select (0 or 1) |
| len_i | input | 4 | Word length minus one |
| wr_i | input | 1 | Data write strobe |
| wdata_i | input | 16 | Word to transmit |
| rd_i | input | 1 | Read strobe; removes the oldest reply |
| rdata_o | output | 16 | Oldest queued reply |
| rx_ready_o | output | 1 | Queue not empty |
| busy_o | output | 1 | Exchange in progress (self-clearing start bit) |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low slave select |

## Verification
A miscounted half-period or bit counter shows on `sclk_o` and `cs_n_o` in the same cycle, because every edge is compared with a reference timeline on every clock. A wrong shift or a write that should have been refused shows on `mosi_o` at the next bit transition. In phase 0 it shows at once, since the first bit is visible while idle. A wrong receive shift or bad queue pointers show on `rdata_o` and `rx_ready_o` as soon as the exchange ends or the next read takes place.

// File: rtl/spi_xe_pkg.sv
package spi_xe_pkg;
    typedef enum logic [1:0] {
        XE_IDLE = 2'd0,
        XE_LOW  = 2'd1,
        XE_HIGH = 2'd2
    } xe_state_e;
endpackage

// File: rtl/spi_xe_fsm.sv
module spi_xe_fsm
    import spi_xe_pkg::*;
#(
    parameter int HALF = 2,
    parameter int LW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          start_i,
    input  logic [LW-1:0] len_i,
    output logic          busy_o,
    output logic          sclk_o,
    output logic          start_ok_o,
    output logic          rise_o,
    output logic          fall_o,
    output logic          last_o,
    output logic          abort_o
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] HRELOAD = HW'(HALF - 1);

    xe_state_e     state_q, state_d;
    logic [HW-1:0] hc_q;
    logic [LW-1:0] bits_q;
    logic          tick;

    assign tick = (hc_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XE_IDLE: if (enable_i && start_i) state_d = XE_LOW;
            XE_LOW: begin
                if (!enable_i)  state_d = XE_IDLE;
                else if (tick)  state_d = XE_HIGH;
            end
            XE_HIGH: begin
                if (!enable_i)  state_d = XE_IDLE;
                else if (tick)  state_d = (bits_q == len_i) ? XE_IDLE : XE_LOW;
            end
            default: state_d = XE_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XE_IDLE;
            hc_q    <= '0;
            bits_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok_o || rise_o || fall_o)
                hc_q <= HRELOAD;
            else if (state_q != XE_IDLE)
                hc_q <= hc_q - 1'b1;
            if (start_ok_o)
                bits_q <= '0;
            else if (fall_o && !last_o)
                bits_q <= bits_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != XE_IDLE);
        sclk_o     = (state_q == XE_HIGH);
        start_ok_o = (state_q == XE_IDLE) && enable_i && start_i;
        rise_o     = (state_q == XE_LOW)  && enable_i && tick;
        fall_o     = (state_q == XE_HIGH) && enable_i && tick;
        last_o     = fall_o && (bits_q == len_i);
        abort_o    = (state_q != XE_IDLE) && !enable_i;
    end

    // R4: an exchange only begins after an enabled start request
    a_r4_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(enable_i && start_i));

    // R11: dropping enable mid-exchange returns to idle next cycle
    a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != XE_IDLE) && !enable_i) |=> (state_q == XE_IDLE));
endmodule

// File: rtl/spi_xe_datapath.sv
module spi_xe_datapath #(
    parameter int DW = 16,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          busy_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          phase_i,
    input  logic [LW-1:0] len_i,
    input  logic          start_ok_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          last_i,
    input  logic          abort_i,
    input  logic          miso_i,
    output logic          mosi_o,
    output logic          push_o,
    output logic [DW-1:0] rx_word_o
);
    logic [DW-1:0] txsr_q, rxsr_q, rx_next;
    logic          mq_q, wr_ok, tx_shift, rx_sample;

    assign wr_ok     = wr_i && enable_i && !busy_i;
    assign tx_shift  = phase_i ? rise_i : (fall_i && !last_i);
    assign rx_sample = phase_i ? fall_i : rise_i;
    assign rx_next   = {rxsr_q[DW-2:0], miso_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txsr_q <= '0;
            rxsr_q <= '0;
            mq_q   <= 1'b0;
        end else begin
            if (wr_ok)
                txsr_q <= wdata_i;
            else if (tx_shift)
                txsr_q <= {txsr_q[DW-2:0], 1'b0};

            if (start_ok_i)
                rxsr_q <= '0;
            else if (rx_sample)
                rxsr_q <= rx_next;

            if (start_ok_i || last_i || abort_i)
                mq_q <= 1'b0;
            else if (phase_i && rise_i)
                mq_q <= txsr_q[len_i];
        end
    end

    assign mosi_o    = phase_i ? mq_q : txsr_q[len_i];
    assign push_o    = last_i;
    assign rx_word_o = phase_i ? rx_next : rxsr_q;

    // R7: disabled and idle, the transmit word cannot change
    a_r7_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !busy_i) |=> $stable(txsr_q));
endmodule

// File: rtl/spi_xe_rxq.sv
module spi_xe_rxq #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] din_i,
    input  logic          pop_i,
    output logic [DW-1:0] dout_o,
    output logic          ready_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);
    localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] count_q;
    logic          push_ok, pop_ok;

    assign push_ok = push_i && (count_q != FULLC);
    assign pop_ok  = pop_i && (count_q != '0);

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q] <= din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wptr_q <= (wptr_q == LASTP) ? '0 : wptr_q + 1'b1;
            if (pop_ok)  rptr_q <= (rptr_q == LASTP) ? '0 : rptr_q + 1'b1;
            count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    assign ready_o = (count_q != '0);
    assign dout_o  = ready_o ? mem[rptr_q] : '0;

    // R10: a completion arriving while full is dropped
    a_r10_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_q == FULLC) && push_i && !pop_i) |=> ((count_q == FULLC) && $stable(wptr_q)));

    // R9: reading the only entry clears ready
    a_r9_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && (count_q == CW'(1)) && !push_i) |=> !ready_o);
endmodule

// File: rtl/spi_xchg_master.sv
module spi_xchg_master #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int DIV   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable_i,
    input  logic                    start_i,
    input  logic                    phase_i,
    input  logic [$clog2(DW)-1:0]   len_i,
    input  logic                    wr_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic                    rd_i,
    output logic [DW-1:0]           rdata_o,
    output logic                    rx_ready_o,
    output logic                    busy_o,
    output logic                    sclk_o,
    output logic                    mosi_o,
    input  logic                    miso_i,
    output logic                    cs_n_o
);
    localparam int LW   = $clog2(DW);
    localparam int HALF = (DIV >= 2) ? DIV / 2 : 1;

    logic          start_ok, rise, fall, last, abort, push;
    logic [DW-1:0] rx_word;

    spi_xe_fsm #(.HALF(HALF), .LW(LW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .start_i(start_i),
        .len_i(len_i), .busy_o(busy_o), .sclk_o(sclk_o),
        .start_ok_o(start_ok), .rise_o(rise), .fall_o(fall),
        .last_o(last), .abort_o(abort)
    );

    spi_xe_datapath #(.DW(DW), .LW(LW)) u_dp (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .busy_i(busy_o),
        .wr_i(wr_i), .wdata_i(wdata_i), .phase_i(phase_i), .len_i(len_i),
        .start_ok_i(start_ok), .rise_i(rise), .fall_i(fall), .last_i(last),
        .abort_i(abort), .miso_i(miso_i), .mosi_o(mosi_o),
        .push_o(push), .rx_word_o(rx_word)
    );

    spi_xe_rxq #(.DW(DW), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push_i(push), .din_i(rx_word),
        .pop_i(rd_i), .dout_o(rdata_o), .ready_o(rx_ready_o)
    );

    assign cs_n_o = !busy_o;

    // R1: the serial clock only pulses inside a selected frame
    a_r1_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);
endmodule

// File: tb/sim_spi_xchg_master.sv
module sim_spi_xchg_master;
    localparam int HALF  = 2;
    localparam int DEPTH = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 0, st = 0, ph = 0, wr = 0, rd = 0, miso = 0;
    logic [3:0]  len = 0;
    logic [15:0] wd = 0, sl = 0;
    logic [15:0] rdata;
    logic rx_ready, busy, sclk, mosi, cs_n;

    int checks = 0, fails = 0, cyc = 0;

    // behavioural reference state
    int m_busy, m_high, m_cnt, m_bits, m_tx, m_rx, m_mq, m_samp;
    int q[$];

    always #10 clk = ~clk;

    spi_xchg_master u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(en), .start_i(st), .phase_i(ph),
        .len_i(len), .wr_i(wr), .wdata_i(wd), .rd_i(rd), .rdata_o(rdata),
        .rx_ready_o(rx_ready), .busy_o(busy), .sclk_o(sclk), .mosi_o(mosi),
        .miso_i(miso), .cs_n_o(cs_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic done_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic int nbits();
        return int'(len) + 1;
    endfunction

    // reference model step and lock-step compare
    always @(posedge clk) begin
        int pre, pushed, pv;
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            done_run();
        end
        if (!rst_n) begin
            m_busy = 0; m_high = 0; m_cnt = 0; m_bits = 0;
            m_tx = 0; m_rx = 0; m_mq = 0; m_samp = 0;
            q.delete();
        end else begin
            pre = q.size(); pushed = 0; pv = 0;
            if (m_busy == 0) begin
                if (en && wr) m_tx = int'(wd);
                if (en && st) begin
                    m_busy = 1; m_high = 0; m_cnt = HALF - 1; m_bits = 0;
                    m_rx = 0; m_mq = 0; m_samp = 0;
                end
            end else if (!en) begin
                m_busy = 0; m_high = 0; m_mq = 0;
            end else if (m_cnt > 0) begin
                m_cnt--;
            end else begin
                m_cnt = HALF - 1;
                if (m_high == 0) begin
                    m_high = 1;
                    if (!ph) begin m_rx = (m_rx << 1) | int'(miso); m_samp++; end
                    else begin
                        m_mq = (m_tx >> (nbits() - 1)) & 1;
                        m_tx = (m_tx << 1) & 16'hFFFF;
                    end
                end else begin
                    m_high = 0;
                    if (ph) begin m_rx = (m_rx << 1) | int'(miso); m_samp++; end
                    if (m_bits == nbits() - 1) begin
                        m_busy = 0; m_mq = 0; pushed = 1; pv = m_rx & 16'hFFFF;
                    end else begin
                        m_bits++;
                        if (!ph) m_tx = (m_tx << 1) & 16'hFFFF;
                    end
                end
            end
            if (rd && pre > 0) void'(q.pop_front());
            if (pushed == 1 && pre < DEPTH) q.push_back(pv);
        end
        #5;
        if (rst_n) begin
            chk("R1 sclk", int'(sclk), m_high);
            chk("R1 cs_n", int'(cs_n), 1 - m_busy);
            chk("R4 busy", int'(busy), m_busy);
            chk("R2 mosi", int'(mosi), ph ? m_mq : ((m_tx >> (nbits() - 1)) & 1));
            chk("R9 rx_ready", int'(rx_ready), (q.size() > 0) ? 1 : 0);
            if (m_busy == 0)
                chk("R8 rdata", int'(rdata), (q.size() > 0) ? q[0] : 0);
        end
    end

    // slave model: presents the next reply bit away from the edge
    always @(negedge clk) begin
        if (m_busy != 0 && m_samp < nbits())
            miso = sl[nbits() - 1 - m_samp];
        else
            miso = 1'b0;
    end

    task automatic run_xchg(input logic [3:0] l, input logic p,
                            input logic [15:0] tw, input logic [15:0] sw);
        @(negedge clk); len = l; ph = p; wd = tw; wr = 1; sl = sw;
        @(negedge clk); wr = 0;
        if (!p) chk("R2 first bit before start (R5 bit N-1)", int'(mosi), int'(tw[l]));
        else    chk("R3 low before first edge", int'(mosi), 0);
        st = 1;
        @(negedge clk); st = 0;
        chk("R4 busy after start", int'(busy), 1);
        chk("R1 select low", int'(cs_n), 0);
        if (p) chk("R3 low in first half", int'(mosi), 0);
        for (int i = 0; i < 300 && busy; i++) @(negedge clk);
        chk("R4 busy clears", int'(busy), 0);
        chk("R1 idle sclk", int'(sclk), 0);
        chk("R1 idle select", int'(cs_n), 1);
    endtask

    task automatic rd_one(input logic [15:0] exp, input string tag);
        @(negedge clk);
        chk({tag, " ready"}, int'(rx_ready), 1);
        chk({tag, " data"}, int'(rdata), int'(exp));
        rd = 1;
        @(negedge clk); rd = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R8 reset rdata", int'(rdata), 0);
        chk("R9 reset ready", int'(rx_ready), 0);
        chk("R1 reset select", int'(cs_n), 1);
        chk("R1 reset sclk", int'(sclk), 0);
        en = 1;

        // 8-bit, phase 0
        run_xchg(4'd7, 1'b0, 16'h00A5, 16'h003C);
        rd_one(16'h003C, "R6 phase0 byte");
        @(negedge clk); chk("R9 empty after read", int'(rx_ready), 0);

        // 16-bit, phase 1
        run_xchg(4'd15, 1'b1, 16'h8001, 16'hBEEF);
        rd_one(16'hBEEF, "R6 phase1 word");

        // 10-bit with upper bits set: justification
        run_xchg(4'd9, 1'b0, 16'hFE5A, 16'hFFFF);
        rd_one(16'h03FF, "R5 R6 10-bit upper zero");

        // single bit, phase 1
        run_xchg(4'd0, 1'b1, 16'h0001, 16'h0001);
        rd_one(16'h0001, "R6 one bit");

        // writes ignored while disabled; start ignored while disabled
        @(negedge clk); len = 4'd7; ph = 0; wd = 16'h0080; wr = 1;
        @(negedge clk); wr = 0; chk("R2 loaded bit", int'(mosi), 1);
        en = 0; wd = 16'h0000; wr = 1;
        @(negedge clk); wr = 0; st = 1;
        chk("R7 write refused when disabled", int'(mosi), 1);
        @(negedge clk); st = 0;
        chk("R4 start refused when disabled", int'(busy), 0);
        en = 1;

        // write during exchange is refused
        @(negedge clk); len = 4'd15; ph = 0; wd = 16'hFFFF; wr = 1; sl = 16'h1234;
        @(negedge clk); wr = 0; st = 1;
        @(negedge clk); st = 0;
        repeat (5) @(negedge clk);
        wd = 16'h0000; wr = 1;
        @(negedge clk); wr = 0;
        chk("R7 write refused while busy", int'(mosi), 1);
        for (int i = 0; i < 300 && busy; i++) @(negedge clk);
        rd_one(16'h1234, "R6 after refused write");

        // fill queue beyond depth
        for (int i = 0; i < 9; i++)
            run_xchg(4'd3, 1'b0, 16'(i), 16'(i + 1));
        for (int i = 0; i < 8; i++)
            rd_one(16'(i + 1), "R10 queue order");
        @(negedge clk);
        chk("R10 ninth reply dropped", int'(rx_ready), 0);
        chk("R8 empty rdata", int'(rdata), 0);

        // abort by disabling
        @(negedge clk); len = 4'd15; ph = 1; wd = 16'hAAAA; wr = 1; sl = 16'h5555;
        @(negedge clk); wr = 0; st = 1;
        @(negedge clk); st = 0;
        repeat (10) @(negedge clk);
        en = 0;
        @(negedge clk);
        chk("R11 idle after abort", int'(busy), 0);
        chk("R11 select released", int'(cs_n), 1);
        chk("R11 nothing queued", int'(rx_ready), 0);
        en = 1;
        repeat (4) @(negedge clk);
        done_run();
    end
endmodule